// File: doc/BRIEF.md
# Widening Multiply-Accumulate by Lane

This block is a vector datapath that multiplies two unsigned 32-bit elements by one broadcast 32-bit scalar and folds the 64-bit products into a two-element 64-bit accumulator. A select input picks the lower or upper pair of the four-element source vector. A 2-bit index picks which element of a second four-element vector becomes the scalar. A mode input chooses whether the products are added to the accumulator or taken away from it.

The block sits inside a vector execution unit. It sees no register file. The caller presents the three 128-bit operands and the control bits, and it receives the 128-bit result. The `PIPE` parameter sets the timing. With `PIPE=1` a single register stage gives a fixed latency of one cycle, and a valid flag travels with the data. With `PIPE=0` the result is combinational.

Top module: `wmac_lane`

## Requirements
- R1: With `hi_half_i=0`, the multiplicands are source elements 0 and 1, where element k is `src_i[32k+31:32k]`.
- R2: With `hi_half_i=1`, the multiplicands are source elements 2 and 3.
- R3: `lane_i` (0 to 3) picks `scal_i[32*lane_i+31:32*lane_i]` as the scalar, and that scalar multiplies both selected source elements.
- R4: Both multiplicands are unsigned, and each product keeps all 64 bits. For example, 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE00000001.
- R5: With `sub_i=0`, result element e is accumulator element e plus product e, modulo 2^64. There is no saturation and no carry output.
- R6: With `sub_i=1`, result element e is accumulator element e minus product e, modulo 2^64. There is no borrow output.
- R7: Element e of the result and of the accumulator sits at bits [64e+63:64e]. Result element 0 comes from the lower selected source element and result element 1 from the upper one.
- R8: With `PIPE=1`, `valid_o` equals `valid_i` of the previous cycle. `res_o` shows the result of the operands presented in that cycle. Reset clears `valid_o` and `res_o` to 0.
- R9: With `PIPE=1`, a cycle with `valid_i=0` leaves `res_o` unchanged.
- R10: With `PIPE=0`, `valid_o` follows `valid_i` and `res_o` follows the operands in the same cycle, whether or not `valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid |
| hi_half_i | input | 1 | Selects the upper source pair when 1 |
| sub_i | input | 1 | Subtracts the products when 1, adds them when 0 |
| lane_i | input | 2 | Index of the scalar element in `scal_i` |
| src_i | input | 128 | Source vector, four 32-bit elements |
| scal_i | input | 128 | Scalar source vector, four 32-bit elements |
| acc_i | input | 128 | Accumulator, two 64-bit elements |
| valid_o | output | 1 | Result valid |
| res_o | output | 128 | Result, two 64-bit elements |

## Verification
The bench builds two copies side by side. `dut_i` uses the default `PIPE=1`, which brings the one-cycle latency, the reset values and the hold on idle cycles within reach. A second instance uses `PIPE=0`, which lets every operand set be checked in the same cycle it is applied. Both copies run the same stimulus: directed cases for each half, all four lanes and both modes, all-ones operands that wrap both the add and the subtract, and a random sweep.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  localparam int unsigned ELEM_W_DEF = 32;
  localparam int unsigned N_OUT_DEF  = 2;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } wmac_op_e;
endpackage

// File: rtl/wmac_opsel.sv
module wmac_opsel #(
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned N_OUT  = 2,
  localparam int unsigned N_SRC  = 2 * N_OUT,
  localparam int unsigned LANE_W = $clog2(N_SRC),
  localparam int unsigned VEC_W  = ELEM_W * N_SRC
) (
  input  logic                          hi_half_i,
  input  logic [LANE_W-1:0]             lane_i,
  input  logic [VEC_W-1:0]              src_i,
  input  logic [VEC_W-1:0]              scal_i,
  output logic [N_OUT-1:0][ELEM_W-1:0]  mul_a_o,
  output logic [ELEM_W-1:0]             mul_b_o
);
  logic [N_SRC-1:0][ELEM_W-1:0] src_el;
  logic [N_SRC-1:0][ELEM_W-1:0] scal_el;

  assign src_el  = src_i;
  assign scal_el = scal_i;
  assign mul_b_o = scal_el[lane_i];

  for (genvar e = 0; e < N_OUT; e++) begin : g_half
    assign mul_a_o[e] = hi_half_i ? src_el[N_OUT+e] : src_el[e];
  end
endmodule

// File: rtl/wmac_elem.sv
module wmac_elem
  import wmac_pkg::*;
#(
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned ACC_W = 2 * ELEM_W
) (
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  wmac_op_e          op_i,
  output logic [ACC_W-1:0]  res_o
);
  logic [ACC_W-1:0] prod;

  assign prod  = ACC_W'(a_i) * ACC_W'(b_i);
  assign res_o = (op_i == OP_SUB) ? acc_i - prod : acc_i + prod;
endmodule

// File: rtl/wmac_stage.sv
module wmac_stage #(
  parameter int unsigned W    = 128,
  parameter bit          PIPE = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  if (PIPE) begin : g_reg
    logic         valid_q;
    logic [W-1:0] data_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) data_q <= data_i;
      end
    end
    assign valid_o = valid_q;
    assign data_o  = data_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane
  import wmac_pkg::*;
#(
  parameter int unsigned ELEM_W = ELEM_W_DEF,
  parameter int unsigned N_OUT  = N_OUT_DEF,
  parameter bit          PIPE   = 1'b1,
  localparam int unsigned N_SRC  = 2 * N_OUT,
  localparam int unsigned LANE_W = $clog2(N_SRC),
  localparam int unsigned VEC_W  = ELEM_W * N_SRC,
  localparam int unsigned ACC_W  = 2 * ELEM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              hi_half_i,
  input  logic              sub_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [VEC_W-1:0]  scal_i,
  input  logic [VEC_W-1:0]  acc_i,
  output logic              valid_o,
  output logic [VEC_W-1:0]  res_o
);
  logic [N_OUT-1:0][ELEM_W-1:0] mul_a;
  logic [ELEM_W-1:0]            mul_b;
  logic [N_OUT-1:0][ACC_W-1:0]  acc_el;
  logic [N_OUT-1:0][ACC_W-1:0]  res_el;
  wmac_op_e                     op;

  assign acc_el = acc_i;
  assign op     = sub_i ? OP_SUB : OP_ADD;

  wmac_opsel #(.ELEM_W(ELEM_W), .N_OUT(N_OUT)) opsel_i (
    .hi_half_i(hi_half_i),
    .lane_i   (lane_i),
    .src_i    (src_i),
    .scal_i   (scal_i),
    .mul_a_o  (mul_a),
    .mul_b_o  (mul_b)
  );

  for (genvar e = 0; e < N_OUT; e++) begin : g_elem
    wmac_elem #(.ELEM_W(ELEM_W)) elem_i (
      .a_i  (mul_a[e]),
      .b_i  (mul_b),
      .acc_i(acc_el[e]),
      .op_i (op),
      .res_o(res_el[e])
    );
  end

  wmac_stage #(.W(VEC_W), .PIPE(PIPE)) stage_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (res_el),
    .valid_o(valid_o),
    .data_o (res_o)
  );
endmodule

// File: rtl/wmac_lane_chk.sv
module wmac_lane_chk #(
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned N_OUT  = 2,
  parameter bit          PIPE   = 1'b1,
  localparam int unsigned N_SRC  = 2 * N_OUT,
  localparam int unsigned LANE_W = $clog2(N_SRC),
  localparam int unsigned VEC_W  = ELEM_W * N_SRC,
  localparam int unsigned ACC_W  = 2 * ELEM_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              hi_half_i,
  input logic              sub_i,
  input logic [LANE_W-1:0] lane_i,
  input logic [VEC_W-1:0]  src_i,
  input logic [VEC_W-1:0]  scal_i,
  input logic [VEC_W-1:0]  acc_i,
  input logic              valid_o,
  input logic [VEC_W-1:0]  res_o
);
  function automatic logic [VEC_W-1:0] model(
    input logic hi, input logic sb, input logic [LANE_W-1:0] ln,
    input logic [VEC_W-1:0] s, input logic [VEC_W-1:0] k, input logic [VEC_W-1:0] a);
    logic [VEC_W-1:0] r;
    logic [ACC_W-1:0] p;
    r = '0;
    for (int e = 0; e < int'(N_OUT); e++) begin
      p = ACC_W'(s[(hi ? N_OUT + e : e) * ELEM_W +: ELEM_W]) * ACC_W'(k[ln * ELEM_W +: ELEM_W]);
      r[e * ACC_W +: ACC_W] = sb ? a[e * ACC_W +: ACC_W] - p : a[e * ACC_W +: ACC_W] + p;
    end
    return r;
  endfunction

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  if (PIPE) begin : g_pipe
    p_reset_clear_r8: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && res_o == '0));
    p_valid_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> valid_o == $past(valid_i));
    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && !$past(valid_i)) |-> $stable(res_o));
    p_result_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $past(valid_i)) |->
      res_o == model($past(hi_half_i), $past(sub_i), $past(lane_i),
                     $past(src_i), $past(scal_i), $past(acc_i)));
  end else begin : g_comb
    p_comb_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);
    p_comb_result_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_o == model(hi_half_i, sub_i, lane_i, src_i, scal_i, acc_i));
  end
endmodule

bind wmac_lane wmac_lane_chk #(.ELEM_W(ELEM_W), .N_OUT(N_OUT), .PIPE(PIPE)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .hi_half_i(hi_half_i),
  .sub_i(sub_i), .lane_i(lane_i), .src_i(src_i), .scal_i(scal_i), .acc_i(acc_i),
  .valid_o(valid_o), .res_o(res_o)
);

// File: tb/wmac_lane_tb_top.sv
`timescale 1ns/1ps
module wmac_lane_tb_top;
  localparam time TCLK = 20ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         valid = 1'b0, hi = 1'b0, sb = 1'b0;
  logic [1:0]   lane = '0;
  logic [127:0] src = '0, scal = '0, acc = '0;
  logic         pv, cv;
  logic [127:0] pres, cres;

  int checks = 0, errors = 0;
  logic         exp_pv = 1'b0;
  logic [127:0] exp_pres = '0;

  always #(TCLK/2) clk = ~clk;

  wmac_lane #(.PIPE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .hi_half_i(hi), .sub_i(sb),
    .lane_i(lane), .src_i(src), .scal_i(scal), .acc_i(acc), .valid_o(pv), .res_o(pres));

  wmac_lane #(.PIPE(1'b0)) dut_comb_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .hi_half_i(hi), .sub_i(sb),
    .lane_i(lane), .src_i(src), .scal_i(scal), .acc_i(acc), .valid_o(cv), .res_o(cres));

  function automatic logic [127:0] ref_mac(logic h, logic s, logic [1:0] l,
                                           logic [127:0] vs, logic [127:0] vk, logic [127:0] va);
    logic [127:0] r;
    longint unsigned p, x, y, a;
    for (int e = 0; e < 2; e++) begin
      x = 64'(vs[(h ? 2 + e : e) * 32 +: 32]);
      y = 64'(vk[l * 32 +: 32]);
      p = x * y;
      a = va[e * 64 +: 64];
      r[e * 64 +: 64] = s ? a - p : a + p;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Applies one operand set at the falling edge, checks both instances.
  task automatic step(string tag, logic v, logic h, logic s, logic [1:0] l,
                      logic [127:0] vs, logic [127:0] vk, logic [127:0] va);
    logic [127:0] r;
    @(negedge clk);
    check({tag, " R8 valid_o"}, 128'(pv), 128'(exp_pv));
    check({tag, " R8/R9 res_o"}, pres, exp_pres);
    valid = v; hi = h; sb = s; lane = l; src = vs; scal = vk; acc = va;
    r = ref_mac(h, s, l, vs, vk, va);
    #1;
    check({tag, " R10 comb valid"}, 128'(cv), 128'(v));
    check({tag, " R10 comb res"}, cres, r);
    exp_pv = v;
    if (v) exp_pres = r;
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [127:0] s0, k0;
  initial begin
    s0 = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    k0 = {32'd40, 32'd30, 32'd20, 32'd10};
    #1 rst_n = 1'b0;
    #(TCLK * 3);
    @(negedge clk);
    check("R8 reset valid_o", 128'(pv), 128'd0);
    check("R8 reset res_o", pres, 128'd0);
    rst_n = 1'b1;
    step("R1 low half", 1, 0, 0, 2'd0, s0, k0, '0);
    step("R2 high half", 1, 1, 0, 2'd0, s0, k0, '0);
    for (int l = 0; l < 4; l++) step("R3 lane", 1, l[0], 0, 2'(l), s0, k0, {64'd5, 64'd7});
    step("R4 all-ones product", 1, 0, 0, 2'd3, '1, '1, '0);
    step("R5 add wrap", 1, 1, 0, 2'd2, '1, '1, '1);
    step("R6 sub wrap", 1, 0, 1, 2'd1, '1, '1, '0);
    step("R6 sub small", 1, 1, 1, 2'd0, s0, k0, {64'd1000, 64'd3});
    step("R7 placement", 1, 0, 0, 2'd1, {64'd0, 32'd9, 32'd2}, k0, {64'h100, 64'h200});
    step("R9 idle hold", 0, 1, 1, 2'd3, '1, '1, '1);
    step("R9 idle hold 2", 0, 0, 0, 2'd0, s0, k0, '0);
    step("R8 resume", 1, 1, 1, 2'd2, s0, k0, {64'd77, 64'd88});
    for (int i = 0; i < 300; i++) begin
      step("R5/R6 random", 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           2'($urandom), {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom});
    end
    step("R8 drain", 0, 0, 0, 2'd0, '0, '0, '0);
    step("R8 drain 2", 0, 0, 0, 2'd0, '0, '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule